// File: doc/BRIEF.md
# Bus Master Burst-Read Sequencer

This block is the initiator for burst reads on a shared 32-bit multiplexed address/data bus whose handshakes are active low. A local requester pulls its request low and holds the start address, command code, burst length and byte enables steady. The block then raises a bus request, waits for the arbiter grant while the bus is idle, loads the transfer parameters, and runs one address phase followed by as many data phases as the burst length asks for.

Every handshake has a one-cycle registered lag. The bus initiator-ready output follows the local readiness input of the cycle before. Each completed data phase (initiator-ready and target-ready both low) shows up on the next cycle as a captured word with a low-word transfer strobe, and the visible burst counter goes down by one. A 4-bit status code steps through idle (0), address loading (1), bus transaction (2) and complete (3); codes 4 to 15 are never produced. Frame is released in the cycle where the final data phase starts, and initiator-ready is then held until that phase completes.

Top module: `burst_rd_master`

## Requirements
- R1: `bus_req_n_o` goes low in the cycle after `loc_req_n_i` is low. It goes high in the cycle after one where `bus_frame_n_o` was low and `loc_req_n_i` was high.
- R2: `loc_gnt_n_o` goes low in the cycle after one where `bus_gnt_n_i` was low and the bus was idle (`bus_frame_n_i` and `bus_irdy_n_i` both high) or a transfer was running. It goes high in the cycle after `bus_gnt_n_i` is high.
- R3: When status is 0 and, in one cycle, `loc_req_n_i` and `bus_gnt_n_i` are low with the bus idle, the status reads 1 in the next cycle. Address, command and length are taken at the end of that status-1 cycle, so later changes on those inputs have no effect.
- R4: The cycle after status 1 is the address phase. In it the status is 2, `bus_frame_n_o` is low, `bus_ad_oe_o` is 1, `bus_ad_o` carries the address, `bus_cbe_n_o` carries the command and `loc_cnt_o` equals the burst length.
- R5: In the data phases, `bus_ad_oe_o` is 0 and `bus_cbe_oe_o` is 1. `bus_cbe_n_o` carries the byte enables sampled on `loc_be_n_i` during the address phase, so later changes on that input have no effect.
- R6: `bus_irdy_n_o` goes low only in a data-phase cycle following one where `loc_rdy_n_i` was low. There is one exception: once the final phase has started, it stays low until that phase completes.
- R7: A data phase completes in a cycle where `bus_irdy_n_o` and `bus_trdy_n_i` are both low. In the next cycle `loc_data_o` holds the word from `bus_ad_i`, `loc_lo_xfer_n_o` is low and `loc_cnt_o` is one lower. In every other cycle `loc_lo_xfer_n_o` is high. `loc_hi_xfer_n_o` and `loc_wide_n_o` are always high (32-bit transfer).
- R8: In data phases, `bus_frame_n_o` is high exactly when `loc_cnt_o` is 1 and `bus_irdy_n_o` is low. Otherwise it is low.
- R9: After the last data phase completes, the status is 3 for one cycle with `bus_irdy_n_o` and `bus_frame_n_o` high, and then it returns to 0.
- R10: While the bus is not idle, a grant and a request leave the status at 0.
- R11: In reset, and in the first cycle after it, the status is 0, all active-low outputs are high and `bus_ad_oe_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| loc_req_n_i | input | 1 | Local burst-read request, active low |
| loc_addr_i | input | 32 | Start address |
| loc_cmd_i | input | 4 | Bus command code |
| loc_len_i | input | LEN_W | Burst length in words (1 or more) |
| loc_be_n_i | input | 4 | Byte enables for the data phases, active low |
| loc_rdy_n_i | input | 1 | Local side ready to accept data, active low |
| loc_gnt_n_o | output | 1 | Local grant indication, active low |
| loc_status_o | output | 4 | Progress code: 0 idle, 1 load, 2 transaction, 3 complete |
| loc_cnt_o | output | LEN_W | Words still to be transferred |
| loc_data_o | output | 32 | Last captured word |
| loc_lo_xfer_n_o | output | 1 | Low-word transfer strobe, active low |
| loc_hi_xfer_n_o | output | 1 | High-word transfer strobe, always high |
| loc_wide_n_o | output | 1 | Wide-transfer indicator, high means 32-bit |
| bus_req_n_o | output | 1 | Bus request to the arbiter |
| bus_gnt_n_i | input | 1 | Bus grant from the arbiter |
| bus_frame_n_i | input | 1 | Observed frame on the bus |
| bus_irdy_n_i | input | 1 | Observed initiator-ready on the bus |
| bus_frame_n_o | output | 1 | Frame driven by this block |
| bus_irdy_n_o | output | 1 | Initiator-ready driven by this block |
| bus_trdy_n_i | input | 1 | Target-ready |
| bus_ad_o | output | 32 | Address/data out |
| bus_ad_oe_o | output | 1 | Address/data output enable |
| bus_ad_i | input | 32 | Address/data in |
| bus_cbe_n_o | output | 4 | Command / byte enables |
| bus_cbe_oe_o | output | 1 | Command/byte-enable output enable |

## Verification
The assertions take for granted that the requester keeps `loc_req_n_i` low, with address, command and length steady, until it sees status 1. They also assume the burst length is never zero. The bench acts as requester, arbiter and target, and it follows both rules in every transfer. It changes the address, length and byte-enable inputs only after the cycle in which each is sampled. The sweep covers burst lengths 1 to 5 and 255, several local-ready and target-ready patterns, and zero to two cycles of a foreign busy bus before the start.

// File: rtl/brm_pkg.sv
package brm_pkg;
  typedef enum logic [2:0] {
    S_IDLE, S_LOAD, S_ADDR, S_DATA, S_DONE
  } seq_e;

  localparam logic [3:0] STAT_IDLE = 4'd0;
  localparam logic [3:0] STAT_LOAD = 4'd1;
  localparam logic [3:0] STAT_XFER = 4'd2;
  localparam logic [3:0] STAT_DONE = 4'd3;
endpackage

// File: rtl/brm_arb.sv
module brm_arb (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic loc_req_n_i,
  input  logic bus_gnt_n_i,
  input  logic bus_idle_i,
  input  logic busy_i,
  input  logic frame_act_i,
  output logic bus_req_n_o,
  output logic loc_gnt_n_o
);
  logic req_q, gnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      req_q <= 1'b0;
      gnt_q <= 1'b0;
    end else begin
      // hold request until a frame has gone out with no new local request
      req_q <= ~loc_req_n_i | (req_q & ~frame_act_i);
      gnt_q <= ~bus_gnt_n_i & (bus_idle_i | busy_i);
    end
  end

  assign bus_req_n_o = ~req_q;
  assign loc_gnt_n_o = ~gnt_q;
endmodule

// File: rtl/brm_seq.sv
module brm_seq
  import brm_pkg::*;
#(
  parameter int LEN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             loc_rdy_n_i,
  input  logic             bus_trdy_n_i,
  input  logic [LEN_W-1:0] len_i,
  output seq_e             state_o,
  output logic [LEN_W-1:0] cnt_o,
  output logic             irdy_o,
  output logic             frame_o,
  output logic             phase_done_o
);
  localparam logic [LEN_W-1:0] ONE = LEN_W'(1);

  seq_e             state_q, state_d;
  logic [LEN_W-1:0] cnt_q;
  logic             irdy_q, irdy_d;
  logic             last, phase_done;

  assign last       = (cnt_q == ONE);
  assign phase_done = (state_q == S_DATA) & irdy_q & ~bus_trdy_n_i;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      S_IDLE:  if (start_i) state_d = S_LOAD;
      S_LOAD:  state_d = S_ADDR;
      S_ADDR:  state_d = S_DATA;
      S_DATA:  if (phase_done && last) state_d = S_DONE;
      S_DONE:  state_d = S_IDLE;
      default: state_d = S_IDLE;
    endcase
  end

  always_comb begin
    irdy_d = 1'b0;
    unique case (state_q)
      S_ADDR: irdy_d = ~loc_rdy_n_i;
      S_DATA: begin
        if (phase_done && last)  irdy_d = 1'b0;
        else if (irdy_q && last) irdy_d = 1'b1;  // final phase: hold until done
        else                     irdy_d = ~loc_rdy_n_i;
      end
      default: irdy_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      irdy_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      irdy_q  <= irdy_d;
      if (state_q == S_LOAD)  cnt_q <= len_i;
      else if (phase_done)    cnt_q <= cnt_q - ONE;
    end
  end

  assign state_o      = state_q;
  assign cnt_o        = cnt_q;
  assign irdy_o       = irdy_q;
  assign phase_done_o = phase_done;
  assign frame_o      = (state_q == S_ADDR) |
                        ((state_q == S_DATA) & ~(last & irdy_q));
endmodule

// File: rtl/brm_dpath.sv
module brm_dpath
  import brm_pkg::*;
#(
  parameter int DW = 32,
  parameter int BW = DW / 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  seq_e          state_i,
  input  logic          phase_done_i,
  input  logic [DW-1:0] loc_addr_i,
  input  logic [BW-1:0] loc_cmd_i,
  input  logic [BW-1:0] loc_be_n_i,
  input  logic [DW-1:0] bus_ad_i,
  output logic [DW-1:0] bus_ad_o,
  output logic          bus_ad_oe_o,
  output logic [BW-1:0] bus_cbe_n_o,
  output logic          bus_cbe_oe_o,
  output logic [DW-1:0] loc_data_o,
  output logic          loc_lo_xfer_n_o
);
  logic [DW-1:0] addr_q, data_q;
  logic [BW-1:0] cmd_q, be_q;
  logic          lo_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
      cmd_q  <= '0;
      be_q   <= '1;
      data_q <= '0;
      lo_q   <= 1'b0;
    end else begin
      if (state_i == S_LOAD) begin
        addr_q <= loc_addr_i;
        cmd_q  <= loc_cmd_i;
      end
      if (state_i == S_ADDR) be_q <= loc_be_n_i;
      if (phase_done_i) data_q <= bus_ad_i;
      lo_q <= phase_done_i;
    end
  end

  always_comb begin
    bus_ad_oe_o  = (state_i == S_ADDR);
    bus_cbe_oe_o = (state_i == S_ADDR) | (state_i == S_DATA);
    bus_ad_o     = bus_ad_oe_o ? addr_q : '0;
    unique case (state_i)
      S_ADDR:  bus_cbe_n_o = cmd_q;
      S_DATA:  bus_cbe_n_o = be_q;
      default: bus_cbe_n_o = '1;
    endcase
  end

  assign loc_data_o      = data_q;
  assign loc_lo_xfer_n_o = ~lo_q;
endmodule

// File: rtl/burst_rd_master.sv
module burst_rd_master
  import brm_pkg::*;
#(
  parameter int DW    = 32,
  parameter int LEN_W = 8,
  localparam int BW   = DW / 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             loc_req_n_i,
  input  logic [DW-1:0]    loc_addr_i,
  input  logic [BW-1:0]    loc_cmd_i,
  input  logic [LEN_W-1:0] loc_len_i,
  input  logic [BW-1:0]    loc_be_n_i,
  input  logic             loc_rdy_n_i,
  output logic             loc_gnt_n_o,
  output logic [3:0]       loc_status_o,
  output logic [LEN_W-1:0] loc_cnt_o,
  output logic [DW-1:0]    loc_data_o,
  output logic             loc_lo_xfer_n_o,
  output logic             loc_hi_xfer_n_o,
  output logic             loc_wide_n_o,
  output logic             bus_req_n_o,
  input  logic             bus_gnt_n_i,
  input  logic             bus_frame_n_i,
  input  logic             bus_irdy_n_i,
  output logic             bus_frame_n_o,
  output logic             bus_irdy_n_o,
  input  logic             bus_trdy_n_i,
  output logic [DW-1:0]    bus_ad_o,
  output logic             bus_ad_oe_o,
  input  logic [DW-1:0]    bus_ad_i,
  output logic [BW-1:0]    bus_cbe_n_o,
  output logic             bus_cbe_oe_o
);
  seq_e state;
  logic bus_idle, start, frame_act, irdy_act, phase_done;

  assign bus_idle = bus_frame_n_i & bus_irdy_n_i;
  assign start    = ~loc_req_n_i & ~bus_gnt_n_i & bus_idle;

  brm_arb u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .loc_req_n_i (loc_req_n_i),
    .bus_gnt_n_i (bus_gnt_n_i),
    .bus_idle_i  (bus_idle),
    .busy_i      (state != S_IDLE),
    .frame_act_i (frame_act),
    .bus_req_n_o (bus_req_n_o),
    .loc_gnt_n_o (loc_gnt_n_o)
  );

  brm_seq #(.LEN_W(LEN_W)) u_seq (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .start_i      (start),
    .loc_rdy_n_i  (loc_rdy_n_i),
    .bus_trdy_n_i (bus_trdy_n_i),
    .len_i        (loc_len_i),
    .state_o      (state),
    .cnt_o        (loc_cnt_o),
    .irdy_o       (irdy_act),
    .frame_o      (frame_act),
    .phase_done_o (phase_done)
  );

  brm_dpath #(.DW(DW), .BW(BW)) u_dpath (
    .clk_i           (clk_i),
    .rst_ni          (rst_ni),
    .state_i         (state),
    .phase_done_i    (phase_done),
    .loc_addr_i      (loc_addr_i),
    .loc_cmd_i       (loc_cmd_i),
    .loc_be_n_i      (loc_be_n_i),
    .bus_ad_i        (bus_ad_i),
    .bus_ad_o        (bus_ad_o),
    .bus_ad_oe_o     (bus_ad_oe_o),
    .bus_cbe_n_o     (bus_cbe_n_o),
    .bus_cbe_oe_o    (bus_cbe_oe_o),
    .loc_data_o      (loc_data_o),
    .loc_lo_xfer_n_o (loc_lo_xfer_n_o)
  );

  always_comb begin
    unique case (state)
      S_LOAD:         loc_status_o = STAT_LOAD;
      S_ADDR, S_DATA: loc_status_o = STAT_XFER;
      S_DONE:         loc_status_o = STAT_DONE;
      default:        loc_status_o = STAT_IDLE;
    endcase
  end

  assign bus_frame_n_o   = ~frame_act;
  assign bus_irdy_n_o    = ~irdy_act;
  assign loc_hi_xfer_n_o = 1'b1;
  assign loc_wide_n_o    = 1'b1;
endmodule

// File: rtl/brm_chk.sv
module brm_chk #(
  parameter int LEN_W = 8
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             loc_req_n_i,
  input logic             loc_rdy_n_i,
  input logic             bus_gnt_n_i,
  input logic             bus_frame_n_i,
  input logic             bus_irdy_n_i,
  input logic             bus_trdy_n_i,
  input logic             bus_req_n_o,
  input logic             loc_gnt_n_o,
  input logic             bus_frame_n_o,
  input logic             bus_irdy_n_o,
  input logic             bus_ad_oe_o,
  input logic [3:0]       loc_status_o,
  input logic [LEN_W-1:0] loc_cnt_o,
  input logic             loc_lo_xfer_n_o
);
  p_req_set_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!loc_req_n_i) |-> !bus_req_n_o);
  p_req_drop_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!bus_frame_n_o && loc_req_n_i) |-> bus_req_n_o);
  p_gnt_set_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(!bus_gnt_n_i && bus_frame_n_i && bus_irdy_n_i) |-> !loc_gnt_n_o);
  p_gnt_drop_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(bus_gnt_n_i) |-> loc_gnt_n_o);
  p_load_cause_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_status_o == 4'd1) |->
      $past(!loc_req_n_i && !bus_gnt_n_i && bus_frame_n_i && bus_irdy_n_i));
  p_addr_phase_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_status_o == 4'd1) |=> (loc_status_o == 4'd2 && !bus_frame_n_o && bus_ad_oe_o));
  p_irdy_cause_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bus_irdy_n_o) |-> $past(!loc_rdy_n_i));
  p_strobe_cause_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !loc_lo_xfer_n_o |-> $past(!bus_irdy_n_o && !bus_trdy_n_i));
  p_cnt_step_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(loc_status_o == 4'd2 && !bus_irdy_n_o && !bus_trdy_n_i) |->
      (loc_cnt_o == $past(loc_cnt_o) - LEN_W'(1)));
  p_frame_last_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_status_o == 4'd2 && loc_cnt_o == LEN_W'(1) && !bus_irdy_n_o) |-> bus_frame_n_o);
  p_done_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_status_o == 4'd3) |-> (bus_irdy_n_o && bus_frame_n_o));
  p_done_exit_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loc_status_o == 4'd3) |=> (loc_status_o == 4'd0));
  p_busy_hold_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(loc_status_o == 4'd0 && !(bus_frame_n_i && bus_irdy_n_i)) |->
      (loc_status_o == 4'd0));
endmodule

bind burst_rd_master brm_chk #(.LEN_W(LEN_W)) u_chk (
  .clk_i           (clk_i),
  .rst_ni          (rst_ni),
  .loc_req_n_i     (loc_req_n_i),
  .loc_rdy_n_i     (loc_rdy_n_i),
  .bus_gnt_n_i     (bus_gnt_n_i),
  .bus_frame_n_i   (bus_frame_n_i),
  .bus_irdy_n_i    (bus_irdy_n_i),
  .bus_trdy_n_i    (bus_trdy_n_i),
  .bus_req_n_o     (bus_req_n_o),
  .loc_gnt_n_o     (loc_gnt_n_o),
  .bus_frame_n_o   (bus_frame_n_o),
  .bus_irdy_n_o    (bus_irdy_n_o),
  .bus_ad_oe_o     (bus_ad_oe_o),
  .loc_status_o    (loc_status_o),
  .loc_cnt_o       (loc_cnt_o),
  .loc_lo_xfer_n_o (loc_lo_xfer_n_o)
);

// File: tb/burst_rd_master_bench.sv
module burst_rd_master_bench;
  localparam int DW = 32;
  localparam int LEN_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic             loc_req_n = 1'b1;
  logic [DW-1:0]    loc_addr = '0;
  logic [3:0]       loc_cmd = '0;
  logic [LEN_W-1:0] loc_len = '0;
  logic [3:0]       loc_be_n = '1;
  logic             loc_rdy_n = 1'b1;
  logic             gnt_n = 1'b1;
  logic             other_busy = 1'b0;
  logic             trdy_n = 1'b1;
  logic [DW-1:0]    ad_in = '0;

  logic             loc_gnt_n, loc_lo_n, loc_hi_n, loc_wide_n;
  logic [3:0]       status;
  logic [LEN_W-1:0] cnt;
  logic [DW-1:0]    data_o, ad_o;
  logic             req_n, frame_n, irdy_n, ad_oe, cbe_oe;
  logic [3:0]       cbe_n;
  logic             frame_obs;

  assign frame_obs = frame_n & ~other_busy;

  burst_rd_master #(.DW(DW), .LEN_W(LEN_W)) u_burst_rd_master (
    .clk_i(clk), .rst_ni(rst_n),
    .loc_req_n_i(loc_req_n), .loc_addr_i(loc_addr), .loc_cmd_i(loc_cmd),
    .loc_len_i(loc_len), .loc_be_n_i(loc_be_n), .loc_rdy_n_i(loc_rdy_n),
    .loc_gnt_n_o(loc_gnt_n), .loc_status_o(status), .loc_cnt_o(cnt),
    .loc_data_o(data_o), .loc_lo_xfer_n_o(loc_lo_n), .loc_hi_xfer_n_o(loc_hi_n),
    .loc_wide_n_o(loc_wide_n), .bus_req_n_o(req_n), .bus_gnt_n_i(gnt_n),
    .bus_frame_n_i(frame_obs), .bus_irdy_n_i(irdy_n), .bus_frame_n_o(frame_n),
    .bus_irdy_n_o(irdy_n), .bus_trdy_n_i(trdy_n), .bus_ad_o(ad_o),
    .bus_ad_oe_o(ad_oe), .bus_ad_i(ad_in), .bus_cbe_n_o(cbe_n), .bus_cbe_oe_o(cbe_oe)
  );

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit pat(input logic [7:0] p, input int t);
    return p[t[2:0]];
  endfunction

  function automatic logic [31:0] wd(input logic [31:0] a, input int k);
    return a + 32'h0011_0101 * (32'(k) + 32'd1);
  endfunction

  task automatic run(input int len, input logic [7:0] rp, input logic [7:0] tp,
                     input int busy, input int idx);
    logic [31:0] a;
    logic [3:0]  cmd, be;
    int rem, k, t;
    bit prev_rdy, hold, prev_done, exp_irdy, tr, done;
    logic [31:0] prev_word;
    a   = 32'h1000_0000 + 32'(idx) * 32'h100;
    cmd = 4'(idx) ^ 4'h6;
    be  = 4'(idx * 3);
    @(negedge clk);
    loc_req_n = 1'b0; loc_addr = a; loc_cmd = cmd; loc_len = LEN_W'(len);
    loc_be_n = be; loc_rdy_n = 1'b1; trdy_n = 1'b1; other_busy = (busy > 0);
    @(negedge clk);
    chk(req_n == 1'b0, "R1 request raised", 32'(req_n), 32'd0);
    gnt_n = 1'b0;
    for (int i = 0; i < busy; i++) begin
      @(negedge clk);
      chk(status == 4'd0, "R10 busy bus holds idle", 32'(status), 32'd0);
      chk(loc_gnt_n == 1'b1, "R2 no local grant on busy bus", 32'(loc_gnt_n), 32'd1);
    end
    other_busy = 1'b0;
    @(negedge clk);
    chk(status == 4'd1, "R3 address loading", 32'(status), 32'd1);
    chk(loc_gnt_n == 1'b0, "R2 local grant", 32'(loc_gnt_n), 32'd0);
    @(negedge clk);
    chk(status == 4'd2, "R4 status in address phase", 32'(status), 32'd2);
    chk(frame_n == 1'b0 && ad_oe == 1'b1, "R4 frame and drive", {frame_n, ad_oe}, 32'd1);
    chk(ad_o == a, "R4 address on bus", ad_o, a);
    chk(cbe_n == cmd, "R4 command on bus", 32'(cbe_n), 32'(cmd));
    chk(cnt == LEN_W'(len), "R3 R4 length loaded", 32'(cnt), 32'(len));
    loc_req_n = 1'b1; gnt_n = 1'b1; loc_addr = ~a; loc_len = '0;
    prev_rdy = pat(rp, 0); loc_rdy_n = ~prev_rdy;
    rem = len; k = 0; t = 1; hold = 0; prev_done = 0; prev_word = '0;
    for (int first = 1; rem > 0; first = 0) begin
      @(negedge clk);
      if (first == 1) begin
        chk(req_n == 1'b1, "R1 request dropped", 32'(req_n), 32'd1);
        chk(loc_gnt_n == 1'b1, "R2 local grant follows bus grant", 32'(loc_gnt_n), 32'd1);
        loc_be_n = ~be;
      end
      exp_irdy = hold | prev_rdy;
      chk(status == 4'd2, "R4 status in data phase", 32'(status), 32'd2);
      chk(ad_oe == 1'b0 && cbe_oe == 1'b1, "R5 output enables", {ad_oe, cbe_oe}, 32'd1);
      chk(cbe_n == be, "R5 byte enables", 32'(cbe_n), 32'(be));
      chk(irdy_n == ~exp_irdy, "R6 initiator ready", 32'(irdy_n), 32'(~exp_irdy));
      chk(frame_n == (rem == 1 && exp_irdy), "R8 frame", 32'(frame_n), 32'(rem == 1 && exp_irdy));
      chk(loc_lo_n == ~prev_done, "R7 low strobe", 32'(loc_lo_n), 32'(~prev_done));
      if (prev_done) chk(data_o == prev_word, "R7 captured word", data_o, prev_word);
      chk(cnt == LEN_W'(rem), "R7 counter", 32'(cnt), 32'(rem));
      chk(loc_hi_n && loc_wide_n, "R7 32-bit indicators", {loc_hi_n, loc_wide_n}, 32'd3);
      tr = pat(tp, t);
      trdy_n = ~tr; ad_in = wd(a, k);
      done = exp_irdy && tr;
      hold = exp_irdy && rem == 1 && !done;
      prev_done = done;
      if (done) begin prev_word = wd(a, k); k++; rem--; end
      prev_rdy = pat(rp, t); loc_rdy_n = ~prev_rdy;
      t++;
    end
    @(negedge clk);
    chk(status == 4'd3, "R9 complete code", 32'(status), 32'd3);
    chk(irdy_n && frame_n, "R9 bus released", {irdy_n, frame_n}, 32'd3);
    chk(!loc_lo_n && data_o == prev_word, "R7 last word", data_o, prev_word);
    trdy_n = 1'b1; loc_rdy_n = 1'b1;
    @(negedge clk);
    chk(status == 4'd0, "R9 back to idle", 32'(status), 32'd0);
    chk(loc_lo_n == 1'b1, "R7 strobe quiet", 32'(loc_lo_n), 32'd1);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  localparam logic [7:0] RP [3] = '{8'hFF, 8'h6D, 8'hB3};
  localparam logic [7:0] TP [4] = '{8'hFF, 8'h5B, 8'hE6, 8'h99};

  initial begin
    int idx;
    idx = 0;
    repeat (3) @(negedge clk);
    chk(status == 4'd0 && req_n && frame_n && irdy_n && loc_gnt_n && loc_lo_n && !ad_oe,
        "R11 reset state", 32'(status), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(status == 4'd0 && req_n && frame_n && irdy_n && loc_gnt_n && loc_lo_n && !ad_oe,
        "R11 after reset", 32'(status), 32'd0);
    for (int len = 1; len <= 5; len++)
      for (int r = 0; r < 3; r++)
        for (int s = 0; s < 4; s++) begin
          run(len, RP[r], TP[s], idx % 3, idx);
          idx++;
        end
    run(255, 8'hFF, 8'hFF, 0, idx);
    run(255, 8'h6D, 8'h5B, 1, idx + 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule